// File: doc/BRIEF.md
# Indirect Masked Queue Table Access Engine

This block sits between a host register bus and two per-queue parameter tables kept in on-chip RAM, one for the upstream direction and one for the downstream direction. The tables cannot be addressed directly. The host reaches an entry in four steps:
- It writes a queue index into an index register.
- It stages data in a pair of 16-bit transfer words. Each direction has its own pair.
- It sets two 16-bit per-bit mask words.
- It writes a command register that names the table, gives the direction of the access and raises a start bit.

On a read, the engine loads the unmasked bits of the chosen entry into that table's transfer words. On a write, it merges the unmasked transfer bits into the entry with a read-modify-write on a synchronous RAM. The start bit stays high until the access has finished, so software polls it as a busy flag. While the start bit is high, the engine ignores host writes to the other registers.

Each entry is 32 bits. Transfer word 0 holds entry bits 15..0 and transfer word 1 holds entry bits 31..16. The mask words follow the same split. The index field is 13 bits wide. The RAM depth is a parameter, and the entry is addressed by the low `DEPTH_LOG2` bits of the index.

Top module: `qtab_xfer_ctrl`

## Requirements
- R1: Host register addresses are 0 index, 1 command, 2/3 upstream transfer word 0/1, 4/5 downstream transfer word 0/1, 6/7 mask word 0/1. The index register holds a 13-bit queue index in bits 12..0, and bits 15..13 always read as 0.
- R2: The command register bits 4..0 select the table. Code 0x10 selects the upstream table and 0x18 selects the downstream table. The two tables hold independent contents.
- R3: Writing 1 to command bit 5 starts an access, and the bit reads 1 while the access runs. It clears by itself: a read leaves it high for 2 cycles after the starting write, and a write leaves it high for 3 cycles.
- R4: Command bit 6 chooses the direction of the access, 1 for a write and 0 for a read.
- R5: On a read, each transfer bit whose mask bit is 0 takes the value of the matching entry bit. Each transfer bit whose mask bit is 1 keeps its value.
- R6: On a write, each entry bit whose mask bit is 0 takes the matching transfer bit. Each entry bit whose mask bit is 1 keeps its old value.
- R7: An access to the upstream table uses only the upstream transfer words, and an access to the downstream table uses only the downstream transfer words. The other pair is left unchanged.
- R8: While command bit 5 is 1, host writes to any register are ignored.
- R9: If command bit 5 is set with a table code other than 0x10 or 0x18, the bit clears one cycle later. No table entry and no transfer word changes.
- R10: After reset, every host register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data for `reg_addr` (combinational) |

## Verification
The bench checks the exact number of cycles the busy bit stays high for reads and for writes. A design that dropped the bit before write-back would let software read stale data. A design that held it too long would stall polling.

It uses partial masks in both directions, which exposes an inverted mask polarity or a merge that picks the wrong operand. It interleaves accesses to the two tables at the same index, which catches a shared transfer pair or an aliased table.

The bench also sends register writes during an access and start requests with an illegal table code. A design that let those through would corrupt the index or mask in mid-transfer, or write a table it was never told to touch.

// File: rtl/qtab_xfer_ctrl.sv
module qtab_xfer_ctrl #(
  parameter int DW         = 16,
  parameter int IDX_W      = 13,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int EW    = 2 * DW;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [4:0] CODE_UP = 5'h10;
  localparam logic [4:0] CODE_DN = 5'h18;
  localparam logic [2:0] A_IDX = 3'd0, A_CMD = 3'd1, A_UX0 = 3'd2, A_UX1 = 3'd3,
                         A_DX0 = 3'd4, A_DX1 = 3'd5, A_MK0 = 3'd6, A_MK1 = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_MRG, S_WB} state_t;

  state_t          state;
  logic [IDX_W-1:0] idx_q;
  logic [4:0]      code_q;
  logic            go_q, dir_q, tsel_q;
  logic [EW-1:0]   ux_q, dx_q, mask_q, rd_q, mrg_q;
  logic [EW-1:0]   up_mem [DEPTH];
  logic [EW-1:0]   dn_mem [DEPTH];

  wire host_wr    = reg_we && !go_q;
  wire code_ok    = (code_q == CODE_UP) || (code_q == CODE_DN);
  wire launch     = (state == S_IDLE) && go_q && code_ok;
  wire [DEPTH_LOG2-1:0] ram_idx = idx_q[DEPTH_LOG2-1:0];
  wire [EW-1:0]   xsel    = tsel_q ? dx_q : ux_q;
  wire [EW-1:0]   rd_load = (xsel & mask_q) | (rd_q & ~mask_q);

  generate
    if (DEPTH_LOG2 < IDX_W) begin : g_hi_idx
      logic unused_idx_hi;
      assign unused_idx_hi = ^idx_q[IDX_W-1:DEPTH_LOG2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx_q  <= '0;
      code_q <= '0;
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      tsel_q <= 1'b0;
      ux_q   <= '0;
      dx_q   <= '0;
      mask_q <= '0;
      mrg_q  <= '0;
    end else begin
      if (host_wr) begin
        case (reg_addr)
          A_IDX: idx_q <= reg_wdata[IDX_W-1:0];
          A_CMD: {dir_q, go_q, code_q} <= reg_wdata[6:0];
          A_UX0: ux_q[DW-1:0]    <= reg_wdata;
          A_UX1: ux_q[EW-1:DW]   <= reg_wdata;
          A_DX0: dx_q[DW-1:0]    <= reg_wdata;
          A_DX1: dx_q[EW-1:DW]   <= reg_wdata;
          A_MK0: mask_q[DW-1:0]  <= reg_wdata;
          default: mask_q[EW-1:DW] <= reg_wdata;
        endcase
      end
      case (state)
        S_IDLE: if (go_q) begin
          if (code_ok) begin
            state  <= S_MRG;
            tsel_q <= (code_q == CODE_DN);
          end else begin
            go_q <= 1'b0;
          end
        end
        S_MRG: if (dir_q) begin
          mrg_q <= (rd_q & mask_q) | (xsel & ~mask_q);
          state <= S_WB;
        end else begin
          if (tsel_q) dx_q <= rd_load;
          else        ux_q <= rd_load;
          go_q  <= 1'b0;
          state <= S_IDLE;
        end
        default: begin
          go_q  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (launch) rd_q <= (code_q == CODE_DN) ? dn_mem[ram_idx] : up_mem[ram_idx];
    if (state == S_WB) begin
      if (tsel_q) dn_mem[ram_idx] <= mrg_q;
      else        up_mem[ram_idx] <= mrg_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_IDX: reg_rdata[IDX_W-1:0] = idx_q;
      A_CMD: reg_rdata[6:0] = {dir_q, go_q, code_q};
      A_UX0: reg_rdata = ux_q[DW-1:0];
      A_UX1: reg_rdata = ux_q[EW-1:DW];
      A_DX0: reg_rdata = dx_q[DW-1:0];
      A_DX1: reg_rdata = dx_q[EW-1:DW];
      A_MK0: reg_rdata = mask_q[DW-1:0];
      default: reg_rdata = mask_q[EW-1:DW];
    endcase
  end

  assert_bad_code_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && go_q && !code_ok) |=> (!go_q && state == S_IDLE));

  assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> ($stable(idx_q) && $stable(mask_q) && $stable(code_q) && $stable(dir_q)));

  assert_write_busy_to_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MRG && dir_q) |=> (state == S_WB && go_q));

  assert_read_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MRG && !dir_q) |=> (state == S_IDLE && !go_q));

  assert_masked_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB) |-> (((mrg_q ^ rd_q) & mask_q) == '0));

  assert_busy_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> go_q);
endmodule

// File: tb/tb_qtab_xfer_ctrl.sv
module tb_qtab_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qtab_xfer_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  typedef struct packed {
    logic        wr;
    logic        dn;
    logic [15:0] idx;
    logic [31:0] xf;
    logic [31:0] mk;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b0, 16'h0005, 32'h12345678, 32'h00000000, 32'h0},
    '{1'b1, 1'b1, 16'h0005, 32'h9ABCDEF0, 32'h00000000, 32'h0},
    '{1'b0, 1'b0, 16'h0005, 32'h00000000, 32'h00000000, 32'h12345678},
    '{1'b0, 1'b1, 16'h0005, 32'hFFFFFFFF, 32'h00000000, 32'h9ABCDEF0},
    '{1'b1, 1'b0, 16'h0005, 32'hAAAAAAAA, 32'hFFFF0000, 32'h0},
    '{1'b0, 1'b0, 16'h0005, 32'h00000000, 32'h00000000, 32'h1234AAAA},
    '{1'b0, 1'b0, 16'h0005, 32'hFFFFFFFF, 32'h00FF00FF, 32'h12FFAAFF},
    '{1'b1, 1'b1, 16'h00FF, 32'h0F0F0F0F, 32'h00000000, 32'h0},
    '{1'b0, 1'b1, 16'h00FF, 32'h00000000, 32'h00000000, 32'h0F0F0F0F},
    '{1'b0, 1'b1, 16'h0005, 32'h00000000, 32'h00000000, 32'h9ABCDEF0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd32(input logic dn, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(dn ? 3'd4 : 3'd2, lo);
    rd(dn ? 3'd5 : 3'd3, hi);
    d = {hi, lo};
  endtask

  task automatic wait_idle();
    logic [15:0] c;
    for (int i = 0; i < 20; i++) begin
      rd(3'd1, c);
      if (!c[5]) break;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic dn, input logic [15:0] idx, input logic [31:0] xf,
                       input logic [31:0] mk);
    wr(3'd0, idx);
    wr(dn ? 3'd4 : 3'd2, xf[15:0]);
    wr(dn ? 3'd5 : 3'd3, xf[31:16]);
    wr(3'd6, mk[15:0]);
    wr(3'd7, mk[31:16]);
  endtask

  task automatic xfer(input logic w, input logic dn, input logic [15:0] idx,
                      input logic [31:0] xf, input logic [31:0] mk);
    setup(dn, idx, xf, mk);
    wr(3'd1, {9'd0, w, 1'b1, dn ? 5'h18 : 5'h10});
    wait_idle();
  endtask

  initial begin
    logic [15:0] r;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], r);
      chk($sformatf("R10 reset value reg %0d", a), {16'd0, r}, 32'd0);
    end

    wr(3'd0, 16'hFFFF);
    rd(3'd0, r);
    chk("R1 index field 12..0, 15..13 read 0", {16'd0, r}, 32'h1FFF);

    for (int i = 0; i < 10; i++) begin
      xfer(VEC[i].wr, VEC[i].dn, VEC[i].idx, VEC[i].xf, VEC[i].mk);
      if (!VEC[i].wr) begin
        rd32(VEC[i].dn, d);
        chk($sformatf("R2/R5/R6 vector %0d read result", i), d, VEC[i].ex);
      end
    end

    // R7: upstream read leaves downstream transfer pair alone
    setup(1'b1, 16'h0005, 32'h22221111, 32'h0);
    xfer(1'b0, 1'b0, 16'h0005, 32'h0, 32'h0);
    rd32(1'b1, d);
    chk("R7 downstream words untouched by upstream read", d, 32'h22221111);
    rd32(1'b0, d);
    chk("R7 upstream words loaded", d, 32'h1234AAAA);

    // R3/R4: busy length for read
    setup(1'b0, 16'h0005, 32'h0, 32'h0);
    wr(3'd1, 16'h0030);
    rd(3'd1, r); chk("R3 read busy cycle 1", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R3 read busy cycle 2", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R3 read done after 2 cycles", {16'd0, r}, 32'h0010);

    // R3/R4: busy length for write
    setup(1'b0, 16'h0006, 32'h0BADF00D, 32'h0);
    wr(3'd1, 16'h0070);
    rd(3'd1, r); chk("R4 write busy cycle 1", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R4 write busy cycle 2", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R3 write busy cycle 3", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R3 write done after 3 cycles", {16'd0, r}, 32'h0050);
    xfer(1'b0, 1'b0, 16'h0006, 32'h0, 32'h0);
    rd32(1'b0, d);
    chk("R4 write landed in table", d, 32'h0BADF00D);

    // R8: writes during a transfer are ignored
    setup(1'b0, 16'h0007, 32'h00C0FFEE, 32'h0);
    wr(3'd1, 16'h0070);
    wr(3'd0, 16'h0009);
    wr(3'd6, 16'hFFFF);
    wait_idle();
    rd(3'd0, r); chk("R8 index unchanged by busy write", {16'd0, r}, 32'h0007);
    rd(3'd6, r); chk("R8 mask unchanged by busy write", {16'd0, r}, 32'h0);
    xfer(1'b0, 1'b0, 16'h0007, 32'h0, 32'h0);
    rd32(1'b0, d);
    chk("R8 entry written at original index", d, 32'h00C0FFEE);

    // R9: illegal code, read and write
    setup(1'b0, 16'h0005, 32'h00005555, 32'h0);
    wr(3'd1, 16'h0031);
    rd(3'd1, r); chk("R9 bad code busy one cycle", {31'd0, r[5]}, 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R9 bad code clears next cycle", {31'd0, r[5]}, 32'd0);
    rd32(1'b0, d);
    chk("R9 transfer words untouched", d, 32'h00005555);
    wr(3'd1, 16'h0065);
    wait_idle();
    xfer(1'b0, 1'b0, 16'h0005, 32'h0, 32'h0);
    rd32(1'b0, d);
    chk("R9 table entry untouched", d, 32'h1234AAAA);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule